// File: doc/BRIEF.md
# Register-Programmed Block Copy Engine

This block moves a run of bytes from one memory to another without processor involvement. Software writes a source address, a destination address and a set of per-transfer flags through a small word-addressed register slave. It then writes the byte count, and that write starts the copy. The engine has two master ports with the same shape: a local port and a remote port. For each of source and destination, one flag picks the port and another picks whether the address walks forward or stays fixed.

Data moves one 32-bit word at a time. Each word is read from the source, held in a buffer, and then written to the destination. A final word that carries only one to three bytes is masked with byte enables on both the read and the write. When the last write is accepted, a sticky done bit is set and the interrupt output goes high. The interrupt stays high until software clears the bit. A write to the abort register stops any copy in progress at once.

Top module: `dma_copy_engine`

## Requirements
- R1: After reset, status reads 0, `irq` is low, neither port requests, and the control register reads 0.
- R2: Register offsets (byte addresses on `reg_addr`): 0x00 abort, 0x04 control, 0x08 source address, 0x0C destination address, 0x10 byte count, 0x14 status. When idle, a write to control, source or destination reads back the written value. Control keeps only bits [3:0]: bit0 source-walk, bit1 destination-walk, bit2 source-on-local, bit3 destination-on-local.
- R3: A write of a non-zero count to 0x10 while idle starts a copy. A write of zero leaves the engine idle, and neither port requests.
- R4: Each word is read from the source port and then written to the destination port. After completion the destination holds the source bytes in order, and bytes outside the copied range are untouched.
- R5: When a walk flag is set, its address advances by 4 after each word. When it is clear, the address stays fixed, so a fixed destination ends with the last word written. After completion the source and destination registers read back base + 4·words for walking addresses and base for fixed ones, and the count register reads 0.
- R6: Each side uses the port its local flag selects: set means the local port, clear means the remote port. The two ports never request in the same cycle.
- R7: A full word uses byte enables 4'b1111. A final word with r remaining bytes (1 to 3) uses enables (1<<r)-1, which covers the low byte lanes.
- R8: Status reads {done, busy} in bits [1:0]. Done is set when the last write completes, drives `irq`, and stays set until 1 is written to status bit 1. Writing 0 there has no effect. Starting a copy clears done.
- R9: While busy, writes to control, source, destination and count are ignored.
- R10: Any write to 0x00 aborts a copy in progress, clears busy and done, and drops requests on the next cycle.
- R11: A request holds its address, direction and data stable until its port asserts ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| loc_req | output | 1 | Local port request |
| loc_we | output | 1 | Local port write (1) or read (0) |
| loc_addr | output | 32 | Local port byte address |
| loc_wdata | output | 32 | Local port write data |
| loc_be | output | 4 | Local port byte enables |
| loc_ready | input | 1 | Local port accepts the request this cycle |
| loc_rdata | input | 32 | Local port read data, valid with ready |
| rem_req | output | 1 | Remote port request |
| rem_we | output | 1 | Remote port write (1) or read (0) |
| rem_addr | output | 32 | Remote port byte address |
| rem_wdata | output | 32 | Remote port write data |
| rem_be | output | 4 | Remote port byte enables |
| rem_ready | input | 1 | Remote port accepts the request this cycle |
| rem_rdata | input | 32 | Remote port read data, valid with ready |
| irq | output | 1 | Completion interrupt (sticky done) |

## Verification
The sweep covers every byte count from 1 to 13 under all sixteen flag combinations. That includes copies that stay on one port and copies with both addresses fixed. Every ragged tail length (one, two and three bytes) therefore meets every routing choice. A design that masked the tail wrongly would damage the destination byte after the copied range. A design that ignored a walk flag would leave the final address registers or the fixed-destination word wrong. Wrong port steering would show up as writes in the memory that should have stayed untouched. Directed cases stall a port and then try reprogramming and aborting while busy. A design that let those writes through, or that moved on without ready, would change the read-back registers or let the request drop before it was accepted.

// File: rtl/dma_copy_engine.sv
module dma_copy_engine #(
  parameter int AW  = 32,
  parameter int LW  = 16,
  parameter int RAW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic [RAW-1:0] reg_addr,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  output logic          loc_req,
  output logic          loc_we,
  output logic [AW-1:0] loc_addr,
  output logic [31:0]   loc_wdata,
  output logic [3:0]    loc_be,
  input  logic          loc_ready,
  input  logic [31:0]   loc_rdata,
  output logic          rem_req,
  output logic          rem_we,
  output logic [AW-1:0] rem_addr,
  output logic [31:0]   rem_wdata,
  output logic [3:0]    rem_be,
  input  logic          rem_ready,
  input  logic [31:0]   rem_rdata,
  output logic          irq
);
  localparam logic [RAW-1:0] OFF_ABORT = RAW'(5'h00);
  localparam logic [RAW-1:0] OFF_CTRL  = RAW'(5'h04);
  localparam logic [RAW-1:0] OFF_SRC   = RAW'(5'h08);
  localparam logic [RAW-1:0] OFF_DST   = RAW'(5'h0C);
  localparam logic [RAW-1:0] OFF_LEN   = RAW'(5'h10);
  localparam logic [RAW-1:0] OFF_STAT  = RAW'(5'h14);
  localparam logic [LW-1:0]  WORD_B    = LW'(4);
  localparam logic [AW-1:0]  STEP      = AW'(4);

  logic [3:0]    ctrl_q;
  logic [AW-1:0] src_q, dst_q;
  logic [LW-1:0] len_q;
  logic          busy_q, done_q, wphase_q;
  logic [31:0]   buf_q;

  wire src_walk = ctrl_q[0];
  wire dst_walk = ctrl_q[1];
  wire src_loc  = ctrl_q[2];
  wire dst_loc  = ctrl_q[3];

  wire abort    = reg_wr && reg_addr == OFF_ABORT;
  wire idle_wr  = reg_wr && !busy_q;
  wire start    = idle_wr && reg_addr == OFF_LEN && reg_wdata[LW-1:0] != '0;
  wire clr_done = reg_wr && reg_addr == OFF_STAT && reg_wdata[1];

  wire       on_loc  = wphase_q ? dst_loc : src_loc;
  wire       last    = len_q <= WORD_B;
  wire [3:0] be_now  = (len_q >= WORD_B) ? 4'hF : ((4'h1 << len_q[1:0]) - 4'h1);
  wire       ready   = on_loc ? loc_ready : rem_ready;
  wire       step    = busy_q && ready;
  wire [31:0] rd_word = src_loc ? loc_rdata : rem_rdata;

  assign loc_req   = busy_q && on_loc;
  assign rem_req   = busy_q && !on_loc;
  assign loc_we    = wphase_q;
  assign rem_we    = wphase_q;
  assign loc_addr  = wphase_q ? dst_q : src_q;
  assign rem_addr  = wphase_q ? dst_q : src_q;
  assign loc_wdata = buf_q;
  assign rem_wdata = buf_q;
  assign loc_be    = be_now;
  assign rem_be    = be_now;
  assign irq       = done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q   <= '0;
      src_q    <= '0;
      dst_q    <= '0;
      len_q    <= '0;
      busy_q   <= 1'b0;
      done_q   <= 1'b0;
      wphase_q <= 1'b0;
      buf_q    <= '0;
    end else if (abort) begin
      busy_q   <= 1'b0;
      done_q   <= 1'b0;
      wphase_q <= 1'b0;
      len_q    <= '0;
    end else begin
      if (clr_done) done_q <= 1'b0;
      if (busy_q) begin
        if (step && !wphase_q) begin
          buf_q    <= rd_word;
          wphase_q <= 1'b1;
        end else if (step) begin
          wphase_q <= 1'b0;
          if (src_walk) src_q <= src_q + STEP;
          if (dst_walk) dst_q <= dst_q + STEP;
          if (last) begin
            len_q  <= '0;
            busy_q <= 1'b0;
            done_q <= 1'b1;
          end else begin
            len_q <= len_q - WORD_B;
          end
        end
      end else if (idle_wr) begin
        if (reg_addr == OFF_CTRL) ctrl_q <= reg_wdata[3:0];
        if (reg_addr == OFF_SRC)  src_q  <= reg_wdata[AW-1:0];
        if (reg_addr == OFF_DST)  dst_q  <= reg_wdata[AW-1:0];
        if (start) begin
          len_q    <= reg_wdata[LW-1:0];
          busy_q   <= 1'b1;
          done_q   <= 1'b0;
          wphase_q <= 1'b0;
        end
      end
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      OFF_CTRL: reg_rdata = {28'd0, ctrl_q};
      OFF_SRC:  reg_rdata = 32'(src_q);
      OFF_DST:  reg_rdata = 32'(dst_q);
      OFF_LEN:  reg_rdata = 32'(len_q);
      OFF_STAT: reg_rdata = {30'd0, done_q, busy_q};
      default:  reg_rdata = '0;
    endcase
  end

  p_ports_exclusive_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(loc_req && rem_req));

  p_loc_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (loc_req && !loc_ready && !abort) |=> (loc_req && $stable(loc_addr) && $stable(loc_we) && $stable(loc_wdata)));

  p_rem_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (rem_req && !rem_ready && !abort) |=> (rem_req && $stable(rem_addr) && $stable(rem_we) && $stable(rem_wdata)));

  p_be_low_lanes_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (loc_req || rem_req) |-> (loc_be != 4'h0 && ((loc_be & (loc_be + 4'h1)) == 4'h0)));

  p_fixed_src_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !src_walk) |=> $stable(src_q));

  p_fixed_dst_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !dst_walk) |=> $stable(dst_q));

  p_done_from_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_q) |-> $past(busy_q));

  p_busy_done_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy_q && done_q));

  p_busy_locks_ctrl_r9: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |=> $stable(ctrl_q));

  p_abort_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> (!busy_q && !done_q && !loc_req && !rem_req));
endmodule

// File: tb/test_dma_copy_engine.sv
module test_dma_copy_engine;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_wr = 1'b0;
  logic [4:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic loc_req, loc_we, rem_req, rem_we, irq;
  logic [31:0] loc_addr, loc_wdata, rem_addr, rem_wdata;
  logic [3:0] loc_be, rem_be;
  logic loc_ready = 1'b0, rem_ready = 1'b0;
  logic [31:0] loc_rdata, rem_rdata;

  logic [31:0] lmem [0:63];
  logic [31:0] rmem [0:63];
  logic [31:0] exp_l [0:63];
  logic [31:0] exp_r [0:63];

  int checks = 0;
  int fails = 0;
  bit hold = 1'b0;
  int stall_mode = 0;
  int cyc = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_copy_engine i_dma_copy_engine (
    .clk(clk), .rst_n(rst_n),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .loc_req(loc_req), .loc_we(loc_we), .loc_addr(loc_addr), .loc_wdata(loc_wdata),
    .loc_be(loc_be), .loc_ready(loc_ready), .loc_rdata(loc_rdata),
    .rem_req(rem_req), .rem_we(rem_we), .rem_addr(rem_addr), .rem_wdata(rem_wdata),
    .rem_be(rem_be), .rem_ready(rem_ready), .rem_rdata(rem_rdata),
    .irq(irq)
  );

  assign loc_rdata = lmem[loc_addr[7:2]];
  assign rem_rdata = rmem[rem_addr[7:2]];

  always @(negedge clk) begin
    cyc = cyc + 1;
    loc_ready = !hold && (stall_mode == 0 || (cyc % 3) != 0);
    rem_ready = !hold && (stall_mode == 0 || (cyc % 4) != 1);
  end

  always @(posedge clk) begin
    if (loc_req && loc_ready && loc_we)
      for (int b = 0; b < 4; b++)
        if (loc_be[b]) lmem[loc_addr[7:2]][8*b +: 8] = loc_wdata[8*b +: 8];
    if (rem_req && rem_ready && rem_we)
      for (int b = 0; b < 4; b++)
        if (rem_be[b]) rmem[rem_addr[7:2]][8*b +: 8] = rem_wdata[8*b +: 8];
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic init_mem();
    for (int i = 0; i < 64; i++) begin
      lmem[i] = 32'hA5000000 ^ (i * 32'h00030507) ^ 32'h11;
      rmem[i] = 32'h3C000000 ^ (i * 32'h00070B0D) ^ 32'h22;
      exp_l[i] = lmem[i];
      exp_r[i] = rmem[i];
    end
  endtask

  task automatic wait_done(input string req);
    bit seen = 1'b0;
    for (int k = 0; k < 400 && !seen; k++) begin
      @(negedge clk);
      #1 if (irq) seen = 1'b1;
    end
    check(seen, req, 32'(irq), 32'd1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    logic [31:0] v;
    init_mem();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(5'h14, v); check(v == 0, "R1 status", v, 0);
    check(!irq, "R1 irq", 32'(irq), 0);
    check(!loc_req && !rem_req, "R1 requests", {30'd0, loc_req, rem_req}, 0);
    rd(5'h04, v); check(v == 0, "R1 control", v, 0);

    // R2 readback
    wr(5'h04, 32'hFFFF_FFFA); rd(5'h04, v); check(v == 32'hA, "R2 control", v, 32'hA);
    wr(5'h08, 32'h0000_1234); rd(5'h08, v); check(v == 32'h1234, "R2 source", v, 32'h1234);
    wr(5'h0C, 32'h0000_5678); rd(5'h0C, v); check(v == 32'h5678, "R2 destination", v, 32'h5678);

    // R3 zero count does not start
    wr(5'h10, 0);
    rd(5'h14, v); check(v == 0, "R3 zero count status", v, 0);
    check(!loc_req && !rem_req, "R3 zero count requests", {30'd0, loc_req, rem_req}, 0);

    // R9 / R11 / R10 with a stalled port
    hold = 1'b1;
    wr(5'h04, 32'hF); wr(5'h08, 8); wr(5'h0C, 160); wr(5'h10, 40);
    repeat (3) @(negedge clk);
    #1 check(loc_req && !loc_we && loc_addr == 8, "R11 request held while stalled", loc_addr, 8);
    wr(5'h08, 32'h100); wr(5'h0C, 32'h200); wr(5'h04, 0); wr(5'h10, 8);
    rd(5'h08, v); check(v == 8, "R9 source ignored while busy", v, 8);
    rd(5'h0C, v); check(v == 160, "R9 destination ignored while busy", v, 160);
    rd(5'h04, v); check(v == 32'hF, "R9 control ignored while busy", v, 32'hF);
    rd(5'h10, v); check(v == 40, "R9 count ignored while busy", v, 40);
    rd(5'h14, v); check(v == 1, "R9 still busy", v, 1);
    wr(5'h00, 32'h0);
    rd(5'h14, v); check(v == 0, "R10 abort clears status", v, 0);
    #1 check(!loc_req && !rem_req && !irq, "R10 abort drops requests", {29'd0, loc_req, rem_req, irq}, 0);
    hold = 1'b0;

    // Sweep: R4 R5 R6 R7 R8
    for (int len = 1; len <= 13; len++) begin
      for (int fl = 0; fl < 16; fl++) begin
        int nw, errs;
        bit si, di, sl, dl;
        logic [31:0] sv;
        init_mem();
        stall_mode = (len + fl) % 2;
        si = fl[0]; di = fl[1]; sl = fl[2]; dl = fl[3];
        nw = (len + 3) / 4;
        for (int w = 0; w < nw; w++) begin
          int n, sidx, didx;
          n = (len - 4*w) >= 4 ? 4 : len - 4*w;
          sidx = 2 + (si ? w : 0);
          didx = 40 + (di ? w : 0);
          sv = sl ? exp_l[sidx] : exp_r[sidx];
          for (int b = 0; b < n; b++)
            if (dl) exp_l[didx][8*b +: 8] = sv[8*b +: 8];
            else    exp_r[didx][8*b +: 8] = sv[8*b +: 8];
        end
        wr(5'h04, 32'(fl)); wr(5'h08, 8); wr(5'h0C, 160); wr(5'h10, 32'(len));
        wait_done($sformatf("R8 irq len %0d flags %0d", len, fl));
        errs = 0;
        for (int i = 0; i < 64; i++)
          if (lmem[i] !== exp_l[i] || rmem[i] !== exp_r[i]) errs++;
        check(errs == 0, $sformatf("R4 R6 R7 memory len %0d flags %0d", len, fl), 32'(errs), 0);
        rd(5'h08, v); check(v == 32'(8 + (si ? 4*nw : 0)), "R5 final source", v, 32'(8 + (si ? 4*nw : 0)));
        rd(5'h0C, v); check(v == 32'(160 + (di ? 4*nw : 0)), "R5 final destination", v, 32'(160 + (di ? 4*nw : 0)));
        rd(5'h10, v); check(v == 0, "R5 count drained", v, 0);
        rd(5'h14, v); check(v == 2, "R8 done sticky", v, 2);
        if (fl == 5) begin
          wr(5'h14, 0);
          rd(5'h14, v); check(v == 2 && irq, "R8 writing 0 keeps done", v, 2);
        end
        wr(5'h14, 2);
        rd(5'h14, v); check(v == 0 && !irq, "R8 clear done", v, 0);
      end
    end

    summary();
  end
endmodule